// File: doc/BRIEF.md
# Reset-Time Option Byte Loader

This block runs while the device is held in reset. It walks a 6-bit counter through a fixed run of consecutive single-byte reads from nonvolatile memory, one read per clock. It captures every returned byte into an on-block option register file, which the rest of the chip reads as a flat vector of configuration bits. The first two counts read user option bytes from the bottom of program memory. Every later count reads the information area at an address equal to the count. Bytes whose information address lands in the trim window are also pushed out on a trim shadow load port.

The memory is a synchronous read port: a byte requested in one cycle returns in the next. The loader keeps a hold-reset output high until the last byte has been captured. It then drops hold-reset for one cycle and afterwards raises a sticky done flag. An external reset, asserted at any point, throws away all progress and starts the whole run again.

Top module: `opt_loader`

## Requirements
- R1: While rst_n is low, holdReset is 1, done is 0 and every bit of optBits is 0.
- R2: After rst_n rises, memRdEn is 1 in each of the first 43 cycles. In cycle c (0 = the cycle before the first rising edge), memAddr equals c.
- R3: memAddr bits 5:0 carry the count, and every bit above bit 5 is 0 whenever memRdEn is 1.
- R4: memInfoSel is 0 (program memory) for counts 0 and 1, and 1 (information area) for counts 2 to 42.
- R5: The byte read at count N is written into optBits[8N+7:8N] on rising edge N+2 after reset release, one cycle after the memory returns it. That slice reads 0 before that edge.
- R6: Counts 43 to 63 are never presented. After count 42, memRdEn stays 0.
- R7: In cycle c = N+1, for N from 32 to 42, trimLdEn is 1, trimLdIdx is N-32, and trimLdData equals the byte read at count N. At all other times trimLdEn is 0.
- R8: holdReset is 1 in cycles 0 to 43 and 0 from cycle 44 on. done is 0 up to cycle 44 and 1 from cycle 45 on, so there is exactly one cycle in which both are low.
- R9: Pulling rst_n low mid-sequence immediately clears done and optBits and raises holdReset. After release, the sequence restarts from count 0.
- R10: Once done is 1, no further reads occur. optBits does not change even if the memory contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| memRdEn | output | 1 | Read request to the nonvolatile memory |
| memAddr | output | ADDR_W | Read address, upper bits forced to zero |
| memInfoSel | output | 1 | 0 = program memory, 1 = information area |
| memRdData | input | DATA_W | Byte returned one cycle after the request |
| holdReset | output | 1 | Keeps the core in reset while loading |
| done | output | 1 | Sticky load-complete flag |
| optBits | output | NUM_BYTES*DATA_W | Captured option bytes, byte N at bits 8N+7:8N |
| trimLdEn | output | 1 | Trim shadow load strobe |
| trimLdIdx | output | 5 | Trim byte index (information address minus 0x20) |
| trimLdData | output | DATA_W | Trim byte value |

## Verification
If the counter or state is wrong, the fault appears on memAddr or memInfoSel in the very cycle it happens. It also shows one cycle later as the wrong byte in an optBits slice or on the trim port. A release sequence that is off by a cycle shows directly as a shifted holdReset fall or done rise. The bench compares every port on every cycle against a cycle index counted from reset release. It does this across random memory images, directed all-ones and alternating images, and resets injected at random points in the run.

// File: rtl/opt_loader_pkg.sv
package opt_loader_pkg;

  localparam int LDR_CNT_W = 6;

  typedef enum logic [1:0] {
    S_FETCH   = 2'd0,
    S_DRAIN   = 2'd1,
    S_RELEASE = 2'd2,
    S_DONE    = 2'd3
  } ldr_state_e;

  typedef struct packed {
    logic                 rdEn;
    logic [LDR_CNT_W-1:0] rdCnt;
    logic                 capEn;
    logic [LDR_CNT_W-1:0] capIdx;
  } ldr_stb_t;

endpackage

// File: rtl/opt_loader_ctrl.sv
module opt_loader_ctrl
  import opt_loader_pkg::*;
#(
  parameter int NUM_BYTES = 43
) (
  input  logic     clk,
  input  logic     rst_n,
  output ldr_stb_t stb,
  output logic     holdReset,
  output logic     done
);

  localparam logic [LDR_CNT_W-1:0] LAST_CNT = LDR_CNT_W'(NUM_BYTES - 1);

  ldr_state_e           state;
  logic [LDR_CNT_W-1:0] cnt;
  logic                 capEn;
  logic [LDR_CNT_W-1:0] capIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      cnt    <= '0;
      capEn  <= 1'b0;
      capIdx <= '0;
    end else begin
      capEn  <= (state == S_FETCH);
      capIdx <= cnt;
      case (state)
        S_FETCH: begin
          if (cnt == LAST_CNT) state <= S_DRAIN;
          else                 cnt   <= cnt + 1'b1;
        end
        S_DRAIN:   state <= S_RELEASE;
        S_RELEASE: state <= S_DONE;
        default:   state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    stb.rdEn   = (state == S_FETCH);
    stb.rdCnt  = cnt;
    stb.capEn  = capEn;
    stb.capIdx = capIdx;
  end

  assign holdReset = (state == S_FETCH) || (state == S_DRAIN);
  assign done      = (state == S_DONE);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdEn |-> (cnt < LDR_CNT_W'(NUM_BYTES)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdEn && capEn) |-> (cnt == capIdx + 1'b1));

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdReset) |=> $rose(done));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !stb.rdEn));

endmodule

// File: rtl/opt_loader_dp.sv
module opt_loader_dp
  import opt_loader_pkg::*;
#(
  parameter int NUM_BYTES  = 43,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PROG_BYTES = 2,
  parameter int TRIM_BASE  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ldr_stb_t                    stb,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        memRdEn,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memInfoSel,
  output logic [NUM_BYTES*DATA_W-1:0] optBits,
  output logic                        trimLdEn,
  output logic [4:0]                  trimLdIdx,
  output logic [DATA_W-1:0]           trimLdData
);

  localparam int TRIM_W     = 5;
  localparam int TRIM_COUNT = NUM_BYTES - TRIM_BASE;

  // Address generation: count on the low bits, everything above forced low
  assign memRdEn    = stb.rdEn;
  assign memAddr    = {{(ADDR_W - LDR_CNT_W){1'b0}}, stb.rdCnt};
  assign memInfoSel = (stb.rdCnt >= LDR_CNT_W'(PROG_BYTES));

  // Option register file, one byte per count
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_optByte
    logic [DATA_W-1:0] byteQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byteQ <= '0;
      else if (stb.capEn && (stb.capIdx == LDR_CNT_W'(i)))
        byteQ <= memRdData;
    end
    assign optBits[i*DATA_W +: DATA_W] = byteQ;
  end

  // Trim shadow forwarding
  assign trimLdEn   = stb.capEn && (stb.capIdx >= LDR_CNT_W'(TRIM_BASE));
  assign trimLdIdx  = TRIM_W'(stb.capIdx - LDR_CNT_W'(TRIM_BASE));
  assign trimLdData = memRdData;

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capEn |=> $stable(optBits));

  // R7
  trim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trimLdEn |-> (stb.capEn && (trimLdIdx < TRIM_W'(TRIM_COUNT))));

endmodule

// File: rtl/opt_loader.sv
module opt_loader
  import opt_loader_pkg::*;
#(
  parameter int NUM_BYTES  = 43,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PROG_BYTES = 2,
  parameter int TRIM_BASE  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        memRdEn,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memInfoSel,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        holdReset,
  output logic                        done,
  output logic [NUM_BYTES*DATA_W-1:0] optBits,
  output logic                        trimLdEn,
  output logic [4:0]                  trimLdIdx,
  output logic [DATA_W-1:0]           trimLdData
);

  ldr_stb_t stb;

  opt_loader_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .holdReset (holdReset),
    .done      (done)
  );

  opt_loader_dp #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PROG_BYTES(PROG_BYTES),
    .TRIM_BASE (TRIM_BASE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .memRdData  (memRdData),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .memInfoSel (memInfoSel),
    .optBits    (optBits),
    .trimLdEn   (trimLdEn),
    .trimLdIdx  (trimLdIdx),
    .trimLdData (trimLdData)
  );

  // R3
  addr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> (memAddr[ADDR_W-1:LDR_CNT_W] == '0));

  // R8
  hold_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !holdReset);

endmodule

// File: tb/opt_loader_bench.sv
`timescale 1ns/1ps
module opt_loader_bench;

  localparam int NB     = 43;
  localparam int ADDR_W = 16;
  localparam int DW     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic              memInfoSel;
  logic [DW-1:0]     memRdData = '0;
  logic              holdReset;
  logic              done;
  logic [NB*DW-1:0]  optBits;
  logic              trimLdEn;
  logic [4:0]        trimLdIdx;
  logic [DW-1:0]     trimLdData;

  logic [DW-1:0] progMem [2];
  logic [DW-1:0] infoMem [64];

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  opt_loader u_opt_loader (
    .clk(clk), .rst_n(rst_n), .memRdEn(memRdEn), .memAddr(memAddr),
    .memInfoSel(memInfoSel), .memRdData(memRdData), .holdReset(holdReset),
    .done(done), .optBits(optBits), .trimLdEn(trimLdEn),
    .trimLdIdx(trimLdIdx), .trimLdData(trimLdData)
  );

  // Synchronous read memory model, one cycle latency
  always_ff @(posedge clk)
    if (memRdEn)
      memRdData <= memInfoSel ? infoMem[memAddr[5:0]] : progMem[memAddr[0]];

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expByte(input int n);
    return (n < 2) ? progMem[n] : infoMem[n];
  endfunction

  function automatic logic [DW-1:0] optByte(input int n);
    return optBits[n*DW +: DW];
  endfunction

  task automatic fillMem(input int mode);
    for (int i = 0; i < 2; i++)
      progMem[i] = (mode == 1) ? 8'hFF : (mode == 2) ? 8'hA5 ^ 8'(i) : 8'($urandom);
    for (int i = 0; i < 64; i++)
      infoMem[i] = (mode == 1) ? 8'hFF : (mode == 2) ? ((i % 2 == 0) ? 8'h5A : 8'hA5)
                                                     : 8'($urandom);
  endtask

  task automatic checkInReset(input string req);
    chk(holdReset == 1'b1, req, holdReset, 1);
    chk(done == 1'b0, req, done, 0);
    chk(optBits == '0, req, optBits[63:0], 0);
  endtask

  // Runs one sequence from reset release; abortAt >= 0 pulls reset at that cycle
  task automatic runPass(input int abortAt);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c <= 48; c++) begin
      #1;
      if (c == abortAt) begin
        rst_n = 1'b0;
        #1;
        checkInReset("R9");
        chk(memRdEn && memAddr == '0, "R9 restart addr", memAddr, 0);
        @(negedge clk);
        @(negedge clk);
        return;
      end
      // R2 R3 R4 R6
      if (c <= NB - 1) begin
        chk(memRdEn == 1'b1, "R2 rdEn", memRdEn, 1);
        chk(memAddr == ADDR_W'(c), "R2/R3 addr", memAddr, c);
        chk(memInfoSel == (c >= 2), "R4 infoSel", memInfoSel, c >= 2);
      end else begin
        chk(memRdEn == 1'b0, "R6 no extra read", memRdEn, 0);
      end
      // R5
      if (c >= 2 && c - 2 < NB)
        chk(optByte(c - 2) == expByte(c - 2), "R5 byte latched", optByte(c - 2), expByte(c - 2));
      if (c - 1 >= 0 && c - 1 < NB)
        chk(optByte(c - 1) == '0, "R5 not yet latched", optByte(c - 1), 0);
      // R7
      if (c >= 33 && c <= 43) begin
        chk(trimLdEn == 1'b1, "R7 trimEn", trimLdEn, 1);
        chk(trimLdIdx == 5'(c - 33), "R7 trimIdx", trimLdIdx, c - 33);
        chk(trimLdData == infoMem[c - 1], "R7 trimData", trimLdData, infoMem[c - 1]);
      end else begin
        chk(trimLdEn == 1'b0, "R7 trim idle", trimLdEn, 0);
      end
      // R8
      chk(holdReset == (c <= 43), "R8 holdReset", holdReset, c <= 43);
      chk(done == (c >= 45), "R8 done", done, c >= 45);
      @(negedge clk);
    end
    // R5 full image
    for (int n = 0; n < NB; n++)
      chk(optByte(n) == expByte(n), "R5 final image", optByte(n), expByte(n));
  endtask

  task automatic checkQuiet();
    logic [NB*DW-1:0] snap;
    snap = optBits;
    fillMem(0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk(memRdEn == 1'b0, "R10 no read after done", memRdEn, 0);
      chk(done == 1'b1, "R10 done sticky", done, 1);
    end
    chk(optBits == snap, "R10 bits frozen", optBits[63:0], snap[63:0]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fillMem(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    checkInReset("R1");

    runPass(-1);
    checkQuiet();

    for (int m = 1; m <= 2; m++) begin
      rst_n = 1'b0;
      fillMem(m);
      @(negedge clk);
      #1;
      checkInReset("R1");
      runPass(-1);
    end

    for (int p = 0; p < 4; p++) begin
      int ab;
      rst_n = 1'b0;
      fillMem(0);
      @(negedge clk);
      ab = (p == 0) ? 44 : int'($urandom_range(1, 44));
      runPass(ab);
      fillMem(0);
      runPass(-1);
      checkQuiet();
    end

    summary();
    $finish;
  end

endmodule